// File: doc/BRIEF.md
# Scheduler Delta Syntonizer

This block turns a free-running oscillator tick into the delta strobe that paces a time-aware egress scheduler. A delta nominally spans 25 enabled ticks. A reference time-of-day clock runs from the same oscillator, and a software servo corrects that clock's rate. Over time the reference therefore gains or loses scheduler ticks. The block keeps the delta phase-locked to the reference by stretching or shrinking individual deltas by whole ticks.

The reference domain marks each correction-period boundary with a one-cycle pulse. With that pulse it presents the number of ticks the period should have contained. The block compares this with the enabled ticks it actually counted. The signed difference joins a residual. The residual is then worked off over the following deltas, at no more than 5 ticks per delta. Positive drift means the reference ran ahead, so deltas are shortened. Negative drift lengthens them. When the residual reaches zero, deltas return to nominal length, so the long-run average stays at 25 ticks.

Only rate differences can be followed this way. A step of the reference clock is outside the correction range; the scheduler has to be stopped and restarted instead. The residual is clamped to a bounded range, and a flag reports when a boundary's drift did not fit.

Top module: `tick_syntonizer`

## Requirements
- R1: After synchronous active-low reset, `delta_strobe` and `drift_sat` are 0 and `drift_remaining` is 0. The first delta after reset release spans exactly NOM_TICKS (25) enabled ticks.
- R2: `delta_strobe` is high for exactly one clock cycle, the cycle after the clock in which the final tick of a delta was enabled. Cycles with `tick_en` low do not advance the delta: with `tick_en` high on every other cycle, strobes are 50 cycles apart.
- R3: Every delta length lies between NOM_TICKS-MAX_STEP (20) and NOM_TICKS+MAX_STEP (30) enabled ticks.
- R4: On a cycle with `period_pulse` high, the drift is computed as `expected_ticks` minus the enabled ticks counted since the previous boundary. That count starts at reset release and includes the boundary cycle's own tick. Cycles with `tick_en` low are not counted. From the next cycle the drift is added into `drift_remaining`.
- R5: Each delta that starts while the residual r is non-zero has length NOM_TICKS minus clamp(r, ±MAX_STEP), and r is reduced by the same amount. Positive r therefore shortens deltas and negative r lengthens them. Once r is 0, deltas are nominal, and the sum of the lengths over the correction equals count×25 minus the drift.
- R6: A delta already in progress when a boundary arrives keeps the length it was started with. The new residual first affects the delta that starts next.
- R7: `drift_remaining` is held within ±DRIFT_LIMIT (40). `drift_sat` is set at a boundary where the combined residual would have exceeded that range, cleared at a boundary where it did not, and otherwise held.
- R8: A boundary that arrives before the previous residual is used up adds the new drift to what remains. The earlier remainder is not discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Scheduler oscillator tick enable |
| period_pulse | input | 1 | One-cycle correction-period boundary from the reference domain |
| expected_ticks | input | CNT_W (24) | Tick count the ending period should have contained |
| delta_strobe | output | 1 | One-cycle pulse at the end of each delta |
| drift_remaining | output | 16 (signed) | Residual ticks still to be corrected |
| drift_sat | output | 1 | Last boundary's drift was clamped |

## Verification
The bench puts boundaries just after a strobe, so the delta in progress must still come out at full length. A design that applied drift immediately would produce a 24-tick gap shortened again.

It drives drifts of both signs, from single ticks up to the clamp. It checks each delta length and checks that the sum of lengths over a correction equals the nominal total minus the drift. A wrong slew limit or sign shows up there as a wrong length.

A second boundary lands mid-correction to catch a design that overwrites the remainder instead of adding to it. An oversized drift checks the clamp, and that the flag holds until the next boundary. With the tick enable running at half rate, a meter that counted clock cycles rather than ticks would report a grossly wrong drift.

// File: rtl/tsa_pkg.sv
// Shared types for the delta syntonizer.
// Assumes residual magnitudes stay well below 2**(RES_W-1).
package tsa_pkg;
    localparam int RES_W = 16;
    typedef logic signed [RES_W-1:0] resid_t;
endpackage

// File: rtl/tsa_period_meter.sv
// Counts enabled scheduler ticks inside a correction period and forms the
// signed drift (expected minus counted) in the boundary cycle.
// Assumes a period never holds 2**CNT_W ticks or more.
module tsa_period_meter #(
    parameter int CNT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    period_pulse,
    input  logic [CNT_W-1:0]        expected_ticks,
    output logic signed [CNT_W+1:0] drift_raw
);
    logic [CNT_W-1:0] meas_q;
    logic [CNT_W:0]   meas_now;

    // Tick total including this cycle's tick, and its difference from the target.
    always_comb begin
        meas_now  = {1'b0, meas_q} + (CNT_W+1)'(tick_en);
        drift_raw = $signed({2'b00, expected_ticks}) - $signed({1'b0, meas_now});
    end

    // Period tick counter, restarted after each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            meas_q <= '0;
        else if (period_pulse)
            meas_q <= '0;
        else if (tick_en)
            meas_q <= meas_q + 1'b1;
    end

    // Disabled cycles outside a boundary leave the count alone.
    assert_meas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_pulse && !tick_en) |=> $stable(meas_q));
endmodule

// File: rtl/tsa_residual.sv
// Holds the signed residual still to be corrected. It merges new drift at a
// boundary (clamped, with saturation flag) and hands out a per-delta
// adjustment of at most MAX_STEP ticks.
// Assumes DRIFT_LIMIT fits in tsa_pkg::RES_W signed bits.
module tsa_residual
    import tsa_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int MAX_STEP    = 5,
    parameter int DRIFT_LIMIT = 40,
    parameter int ADJ_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    consume,
    input  logic signed [CNT_W+1:0] drift_raw,
    output logic signed [ADJ_W-1:0] adj,
    output resid_t                  resid_q,
    output logic                    sat_q
);
    localparam int SUM_W = CNT_W + 3;
    localparam logic signed [SUM_W-1:0] LIM_S  = SUM_W'(DRIFT_LIMIT);
    localparam resid_t                  LIM_R  = RES_W'(DRIFT_LIMIT);
    localparam resid_t                  STEP_R = RES_W'(MAX_STEP);

    logic signed [SUM_W-1:0] sum;
    logic   over, under;
    resid_t clamped, eff, adj_r, nxt;

    // Merge, clamp, choose this delta's step and the leftover.
    always_comb begin
        sum     = SUM_W'(resid_q) + SUM_W'(drift_raw);
        over    = sum > LIM_S;
        under   = sum < -LIM_S;
        clamped = over ? LIM_R : (under ? -LIM_R : RES_W'(sum));
        eff     = load ? clamped : resid_q;
        adj_r   = (eff > STEP_R) ? STEP_R : ((eff < -STEP_R) ? -STEP_R : eff);
        adj     = ADJ_W'(adj_r);
        nxt     = consume ? (eff - adj_r) : eff;
    end

    // Residual and saturation flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resid_q <= '0;
            sat_q   <= 1'b0;
        end else begin
            resid_q <= nxt;
            if (load)
                sat_q <= over | under;
        end
    end

    assert_resid_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resid_q <= LIM_R) && (resid_q >= -LIM_R));
    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sat_q));
    assert_shrink_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !load && resid_q > 0) |=> (resid_q >= 0 && resid_q < $past(resid_q)));
    assert_shrink_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !load && resid_q < 0) |=> (resid_q <= 0 && resid_q > $past(resid_q)));
endmodule

// File: rtl/tsa_delta_timer.sv
// Counts enabled ticks within the current delta and emits a one-cycle strobe
// after its last tick. The next delta's length is latched at that moment
// from the nominal length minus the supplied adjustment.
// Assumes NOM_TICKS - MAX_STEP >= 2.
module tsa_delta_timer #(
    parameter int NOM_TICKS = 25,
    parameter int MAX_STEP  = 5,
    parameter int ADJ_W     = 4,
    parameter int LEN_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic signed [ADJ_W-1:0] adj,
    output logic                    delta_end,
    output logic                    strobe_q
);
    localparam logic [LEN_W-1:0] NOM_L = LEN_W'(NOM_TICKS);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(NOM_TICKS - MAX_STEP);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(NOM_TICKS + MAX_STEP);

    logic [LEN_W-1:0] cnt_q, len_q;

    // Last tick of the running delta.
    always_comb delta_end = tick_en && (cnt_q == len_q - 1'b1);

    // Tick position, latched length and output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            len_q    <= NOM_L;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= delta_end;
            if (delta_end) begin
                cnt_q <= '0;
                len_q <= NOM_L - LEN_W'(adj);
            end else if (tick_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_len_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= MIN_L) && (len_q <= MAX_L));
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);
    assert_strobe_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> $past(tick_en));
endmodule

// File: rtl/tick_syntonizer.sv
// Top of the delta syntonizer: a period meter feeds drift into the residual
// store, which paces the delta timer's lengths.
// Assumes period_pulse and expected_ticks are already in this clock domain.
module tick_syntonizer #(
    parameter int NOM_TICKS   = 25,
    parameter int MAX_STEP    = 5,
    parameter int DRIFT_LIMIT = 40,
    parameter int CNT_W       = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_en,
    input  logic                              period_pulse,
    input  logic [CNT_W-1:0]                  expected_ticks,
    output logic                              delta_strobe,
    output logic signed [tsa_pkg::RES_W-1:0]  drift_remaining,
    output logic                              drift_sat
);
    localparam int ADJ_W = $clog2(MAX_STEP + 1) + 1;
    localparam int LEN_W = $clog2(NOM_TICKS + MAX_STEP + 1);

    logic signed [CNT_W+1:0] drift_raw;
    logic signed [ADJ_W-1:0] adj;
    logic                    delta_end;

    tsa_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .period_pulse(period_pulse), .expected_ticks(expected_ticks),
        .drift_raw(drift_raw)
    );

    tsa_residual #(.CNT_W(CNT_W), .MAX_STEP(MAX_STEP),
                   .DRIFT_LIMIT(DRIFT_LIMIT), .ADJ_W(ADJ_W)) u_resid (
        .clk(clk), .rst_n(rst_n), .load(period_pulse), .consume(delta_end),
        .drift_raw(drift_raw), .adj(adj), .resid_q(drift_remaining),
        .sat_q(drift_sat)
    );

    tsa_delta_timer #(.NOM_TICKS(NOM_TICKS), .MAX_STEP(MAX_STEP),
                      .ADJ_W(ADJ_W), .LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .adj(adj),
        .delta_end(delta_end), .strobe_q(delta_strobe)
    );
endmodule

// File: tb/sim_tick_syntonizer.sv
module sim_tick_syntonizer;
    localparam int NOM  = 25;
    localparam int STEP = 5;
    localparam int LIM  = 40;
    localparam int CW   = 24;
    localparam int NVEC = 10;
    localparam int VEC_DRIFT [NVEC] = '{0, 3, -7, 12, -12, 5, -5, 1, 40, -40};

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, period_pulse = 1'b0;
    logic [CW-1:0] expected_ticks = '0;
    logic delta_strobe, drift_sat;
    logic signed [15:0] drift_remaining;

    int n_cmp = 0, n_bad = 0, ticks_since = 0, resid_model = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    tick_syntonizer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_pulse(period_pulse),
        .expected_ticks(expected_ticks), .delta_strobe(delta_strobe),
        .drift_remaining(drift_remaining), .drift_sat(drift_sat)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lim);
        return (v > lim) ? lim : ((v < -lim) ? -lim : v);
    endfunction

    // Drive one cycle's inputs, then wait until the following negedge.
    task automatic step(input logic te, input logic pp, input int expv);
        tick_en        = te;
        period_pulse   = pp;
        expected_ticks = CW'(expv);
        @(negedge clk);
        if (rst_n && te) ticks_since++;
        if (rst_n && pp) ticks_since = 0;
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        do begin
            step(1'b1, 1'b0, 0);
            n++;
        end while (!delta_strobe && n < 200);
    endtask

    // Boundary carrying drift d relative to the ticks driven so far.
    task automatic pulse(input int d, input string req);
        int sum_raw;
        sum_raw = resid_model + d;
        step(1'b1, 1'b1, ticks_since + 1 + d);
        resid_model = clampi(sum_raw, LIM);
        check_eq({req, " drift_remaining after boundary"}, int'(drift_remaining), resid_model);
        check_eq("R7 saturation flag", int'(drift_sat), (sum_raw > LIM || sum_raw < -LIM) ? 1 : 0);
    endtask

    // Follow the correction from a delta start until one nominal delta is seen.
    task automatic play(input int drift_total);
        int a, n, total, cnt;
        total = 0;
        cnt   = 0;
        do begin
            a = clampi(resid_model, STEP);
            resid_model -= a;
            wait_strobe(n);
            check_eq("R5 delta length", n, NOM - a);
            check_eq("R3 length in window", (n >= NOM - STEP && n <= NOM + STEP) ? 1 : 0, 1);
            total += n;
            cnt++;
        end while (a != 0);
        check_eq("R5 average length (sum of deltas)", total, cnt * NOM - drift_total);
        check_eq("R5 residual back to zero", int'(drift_remaining), 0);
    endtask

    initial begin
        int n;
        bit ph;
        // R1: reset state
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0);
        check_eq("R1 strobe in reset", int'(delta_strobe), 0);
        check_eq("R1 residual in reset", int'(drift_remaining), 0);
        check_eq("R1 sat in reset", int'(drift_sat), 0);
        rst_n = 1'b1;
        ticks_since = 0;
        wait_strobe(n);
        check_eq("R1 first delta length", n, NOM);
        step(1'b1, 1'b0, 0);
        check_eq("R2 strobe one cycle wide", int'(delta_strobe), 0);
        wait_strobe(n);

        // Vector table: fast and slow reference rates
        for (int v = 0; v < NVEC; v++) begin
            pulse(VEC_DRIFT[v], "R4");
            wait_strobe(n);
            check_eq("R6 in-progress delta unchanged", n + 1, NOM);
            play(VEC_DRIFT[v]);
        end

        // R8: boundary during an unfinished correction
        begin
            int a;
            pulse(12, "R4");
            wait_strobe(n);
            check_eq("R6 in-progress delta unchanged", n + 1, NOM);
            a = clampi(resid_model, STEP);
            resid_model -= a;
            pulse(4, "R8");
            check_eq("R8 remainder merged", int'(drift_remaining), 11);
            wait_strobe(n);
            check_eq("R8 running delta keeps length", n + 1, NOM - a);
            play(11);
        end

        // R7: oversized drift is clamped and flagged until the next boundary
        pulse(60, "R7");
        check_eq("R7 clamped residual", int'(drift_remaining), LIM);
        wait_strobe(n);
        check_eq("R6 in-progress delta unchanged", n + 1, NOM);
        play(LIM);
        check_eq("R7 flag held between boundaries", int'(drift_sat), 1);
        pulse(0, "R7");
        check_eq("R7 flag cleared", int'(drift_sat), 0);
        wait_strobe(n);
        play(0);

        // R2: half-rate ticks
        ph = 1'b0;
        n  = 0;
        do begin step(ph, 1'b0, 0); ph = !ph; n++; end while (!delta_strobe && n < 400);
        n = 0;
        do begin
            step(ph, 1'b0, 0);
            ph = !ph;
            n++;
            if (n == 1) check_eq("R2 strobe low after pulse", int'(delta_strobe), 0);
        end while (!delta_strobe && n < 400);
        check_eq("R2 half-rate delta spacing", n, 2 * NOM);

        // R4: meter counted only enabled ticks through the half-rate stretch
        pulse(-3, "R4");
        check_eq("R4 drift from enabled ticks only", int'(drift_remaining), -3);
        wait_strobe(n);
        check_eq("R6 in-progress delta unchanged", n + 1, NOM);
        play(-3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule